// File: doc/BRIEF.md
# E1 Idle Channel Code Inserter

This block sits in the transmit path of an E1 framer (32 timeslots of 8 bits per frame). For each outgoing timeslot it either sends the payload byte supplied by the framer or replaces it with an 8-bit idle code set by software. Two conditions trigger the replacement. The first is a loopback match: loopback is enabled and the timeslot equals the programmed loopback channel. The second is a set bit in a 32-bit per-timeslot idle select map. Both conditions use the same code word.

The output is one serial bit per bit-clock enable, most significant bit first. A frame-start pulse realigns the internal timeslot and bit counters. The block reports the timeslot it is currently emitting, so the upstream payload source can present the matching byte. The choice between payload and idle code is made once, at the first bit of each timeslot, so a register write can never produce a byte that mixes both sources.

Top module: `e1_idle_inserter`

## Requirements
- R1: After a synchronous active-low reset, the following hold: every register reads 0, `ser_out` is 0, and the position is timeslot 0, bit 7.
- R2: Register addresses are 0 for the idle code (8 bits), 1 for the loopback channel (low 5 bits, upper bits read 0), 2 for loopback enable (bit 0, upper bits read 0), 3 reserved (reads 0), and 4 to 7 for the select map. Address 4+n covers timeslots 8n to 8n+7, and its bit 0 is the lowest of those timeslots. Every register reads back the value last written, through the combinational `rd_data`.
- R3: When loopback enable is 1, the timeslot equal to the loopback channel carries the idle code. When loopback enable is 0, the loopback channel has no effect.
- R4: Any timeslot whose select map bit is 1 carries the idle code, whatever the loopback setting.
- R5: A timeslot that meets neither condition carries `payload_in` unchanged.
- R6: Each byte is sent bit 7 first and bit 0 last. `ser_out` takes the bit for a position in the cycle after the `bit_en` cycle of that position.
- R7: The choice of source and the byte itself are captured at bit 7 of a timeslot. A register write later in that timeslot takes effect from the next timeslot. A write in the same cycle as bit 7 also waits until the next timeslot.
- R8: The position and `ser_out` change only in `bit_en` cycles. After bit 0 of timeslot 31, the position wraps to timeslot 0, bit 7.
- R9: `frame_start` together with `bit_en` makes that cycle timeslot 0, bit 7, whatever the counters held.
- R10: `cur_slot` shows the timeslot of the current position, including the effect of `frame_start`. `payload_in` is sampled only in the `bit_en` cycle at bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Bit-clock enable, one output bit per pulse |
| frame_start | input | 1 | Realigns to timeslot 0, bit 7 when high with bit_en |
| payload_in | input | 8 | Payload byte for the timeslot shown on cur_slot |
| cur_slot | output | 5 | Timeslot of the current position |
| ser_out | output | 1 | Serial output, MSB first |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |

## Verification
The bench builds the block with the default 32 timeslots of 8 bits. This brings all four select map bytes into reach, including the top bit of the last byte, and makes loopback channel 31 and the wrap from slot 31 to slot 0 reachable. At these sizes every full frame is 256 bit cycles. That is short enough to check every timeslot of each configuration in the vector table. It also leaves room for frames with stalled enables, a mid-frame realignment and writes that land inside or at the start of a timeslot.

// File: rtl/e1_ici_pkg.sv
// Shared definitions for the E1 idle channel code inserter.
// Assumes a 3-bit register address space.
package e1_ici_pkg;
    typedef logic [2:0] ici_addr_t;

    localparam ici_addr_t ADR_IDLE = 3'd0;  // idle code word
    localparam ici_addr_t ADR_LCH  = 3'd1;  // loopback channel number
    localparam ici_addr_t ADR_LEN  = 3'd2;  // loopback enable
    localparam int        ADR_MAP_BASE = 4; // first select map byte
endpackage

// File: rtl/e1_ici_regs.sv
// Register file: idle code, loopback channel, loopback enable and the
// per-timeslot select map. Reads are combinational. Assumes SLOTS/BITS
// map registers fit at addresses ADR_MAP_BASE upward.
module e1_ici_regs
    import e1_ici_pkg::*;
#(
    parameter int SLOTS  = 32,
    parameter int BITS   = 8,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  ici_addr_t         wr_addr,
    input  logic [BITS-1:0]   wr_data,
    input  ici_addr_t         rd_addr,
    output logic [BITS-1:0]   rd_data,
    output logic [BITS-1:0]   idle_code,
    output logic [SLOT_W-1:0] loop_ch,
    output logic              loop_en,
    output logic [SLOTS-1:0]  sel_map
);
    localparam int MAP_REGS = SLOTS / BITS;

    logic [BITS-1:0]   idle_q;
    logic [SLOT_W-1:0] lch_q;
    logic              len_q;
    logic [BITS-1:0]   map_q [MAP_REGS];

    // Scalar control registers: idle code, loopback channel and enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_q <= '0;
            lch_q  <= '0;
            len_q  <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADR_IDLE) idle_q <= wr_data;
            if (wr_addr == ADR_LCH)  lch_q  <= wr_data[SLOT_W-1:0];
            if (wr_addr == ADR_LEN)  len_q  <= wr_data[0];
        end
    end

    generate
        for (genvar g = 0; g < MAP_REGS; g++) begin : g_map
            // One select map byte, covering timeslots g*BITS upward.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    map_q[g] <= '0;
                else if (wr_en && wr_addr == 3'(ADR_MAP_BASE + g))
                    map_q[g] <= wr_data;
            end
            assign sel_map[g*BITS +: BITS] = map_q[g];

            // R2
            map_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en && wr_addr == 3'(ADR_MAP_BASE + g) |=> map_q[g] == $past(wr_data));
        end
    endgenerate

    // Read mux over all registers; unused addresses return zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_IDLE: rd_data = idle_q;
            ADR_LCH:  rd_data = BITS'(lch_q);
            ADR_LEN:  rd_data = BITS'(len_q);
            default:  ;
        endcase
        for (int i = 0; i < MAP_REGS; i++)
            if (rd_addr == 3'(ADR_MAP_BASE + i)) rd_data = map_q[i];
    end

    assign idle_code = idle_q;
    assign loop_ch   = lch_q;
    assign loop_en   = len_q;

    // R2
    idle_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_addr == ADR_IDLE |=> idle_q == $past(wr_data));
endmodule

// File: rtl/e1_ici_timing.sv
// Timeslot and bit position counters. Moves on bit_en only. frame_start
// with bit_en forces the current position to timeslot 0, MSB. The
// current position is exposed combinationally.
module e1_ici_timing #(
    parameter int SLOTS  = 32,
    parameter int BITS   = 8,
    parameter int SLOT_W = $clog2(SLOTS),
    parameter int BIT_W  = $clog2(BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              frame_start,
    output logic [SLOT_W-1:0] slot_now,
    output logic [BIT_W-1:0]  bit_now,
    output logic              first_bit
);
    localparam logic [BIT_W-1:0]  BIT_MSB   = BIT_W'(BITS - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] slot_q;
    logic [BIT_W-1:0]  bit_q;

    // Current position, overridden by a frame-start pulse.
    always_comb begin
        slot_now  = frame_start ? '0 : slot_q;
        bit_now   = frame_start ? BIT_MSB : bit_q;
        first_bit = (bit_now == BIT_MSB);
    end

    // Advance one bit per enable, wrapping bits then timeslots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            bit_q  <= BIT_MSB;
        end else if (bit_en) begin
            if (bit_now == '0) begin
                bit_q  <= BIT_MSB;
                slot_q <= (slot_now == SLOT_LAST) ? '0 : slot_now + 1'b1;
            end else begin
                bit_q  <= bit_now - 1'b1;
                slot_q <= slot_now;
            end
        end
    end

    // R9
    realign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && frame_start |=> slot_q == '0 && bit_q == BIT_W'(BITS - 2));
    // R8
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(slot_q) && $stable(bit_q));
    // R8
    wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && !frame_start && slot_q == SLOT_LAST && bit_q == '0
        |=> slot_q == '0 && bit_q == BIT_MSB);
endmodule

// File: rtl/e1_ici_ser.sv
// Source selection and serializer. At the first bit of each timeslot it
// picks the idle code or the payload and captures the byte, then shifts
// it out MSB first, one bit per enable. Assumes a stable register view
// for the duration of the capture cycle.
module e1_ici_ser #(
    parameter int SLOTS  = 32,
    parameter int BITS   = 8,
    parameter int SLOT_W = $clog2(SLOTS),
    parameter int BIT_W  = $clog2(BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              first_bit,
    input  logic [BIT_W-1:0]  bit_now,
    input  logic [SLOT_W-1:0] slot_now,
    input  logic [BITS-1:0]   payload,
    input  logic [BITS-1:0]   idle_code,
    input  logic              loop_en,
    input  logic [SLOT_W-1:0] loop_ch,
    input  logic [SLOTS-1:0]  sel_map,
    output logic              ser_out
);
    logic            subst;
    logic [BITS-1:0] chosen;
    logic [BITS-1:0] byte_q;
    logic            ser_q;

    // Substitution request from either the loopback match or the map.
    always_comb begin
        subst  = (loop_en && slot_now == loop_ch) || sel_map[slot_now];
        chosen = subst ? idle_code : payload;
    end

    // Capture the timeslot byte at its first bit and drive the line bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_q <= '0;
            ser_q  <= 1'b0;
        end else if (bit_en) begin
            if (first_bit) begin
                byte_q <= chosen;
                ser_q  <= chosen[BITS-1];
            end else begin
                ser_q  <= byte_q[bit_now];
            end
        end
    end

    assign ser_out = ser_q;

    // R3 R4
    idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && first_bit && subst |=> ser_out == $past(idle_code[BITS-1]));
    // R5
    pass_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && first_bit && !subst |=> ser_out == $past(payload[BITS-1]));
    // R7
    byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && !first_bit |=> $stable(byte_q));
    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(ser_out));
endmodule

// File: rtl/e1_idle_inserter.sv
// Top of the E1 idle channel code inserter. Connects the register file,
// the position counters and the serializer. Assumes the payload source
// presents the byte for cur_slot in the bit_en cycle at bit 7.
module e1_idle_inserter
    import e1_ici_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter int BITS  = 8,
    localparam int SLOT_W = $clog2(SLOTS),
    localparam int BIT_W  = $clog2(BITS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              frame_start,
    input  logic [BITS-1:0]   payload_in,
    output logic [SLOT_W-1:0] cur_slot,
    output logic              ser_out,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [BITS-1:0]   wr_data,
    input  logic [2:0]        rd_addr,
    output logic [BITS-1:0]   rd_data
);
    logic [BITS-1:0]   idle_code;
    logic [SLOT_W-1:0] loop_ch;
    logic              loop_en;
    logic [SLOTS-1:0]  sel_map;
    logic [SLOT_W-1:0] slot_now;
    logic [BIT_W-1:0]  bit_now;
    logic              first_bit;

    e1_ici_regs #(.SLOTS(SLOTS), .BITS(BITS), .SLOT_W(SLOT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .idle_code(idle_code), .loop_ch(loop_ch), .loop_en(loop_en),
        .sel_map(sel_map)
    );

    e1_ici_timing #(.SLOTS(SLOTS), .BITS(BITS), .SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_timing (
        .clk(clk), .rst_n(rst_n),
        .bit_en(bit_en), .frame_start(frame_start),
        .slot_now(slot_now), .bit_now(bit_now), .first_bit(first_bit)
    );

    e1_ici_ser #(.SLOTS(SLOTS), .BITS(BITS), .SLOT_W(SLOT_W), .BIT_W(BIT_W)) u_ser (
        .clk(clk), .rst_n(rst_n),
        .bit_en(bit_en), .first_bit(first_bit), .bit_now(bit_now),
        .slot_now(slot_now), .payload(payload_in),
        .idle_code(idle_code), .loop_en(loop_en), .loop_ch(loop_ch),
        .sel_map(sel_map), .ser_out(ser_out)
    );

    assign cur_slot = slot_now;
endmodule

// File: tb/e1_idle_inserter_test.sv
`timescale 1ns/1ps
module e1_idle_inserter_test;
    localparam int SLOTS = 32;
    localparam int BITS  = 8;
    localparam int NVEC  = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       frame_start = 1'b0;
    logic [7:0] payload_in = '0;
    logic [4:0] cur_slot;
    logic       ser_out;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Bench shadow of the programmed configuration.
    logic [7:0]  sh_idle = '0;
    logic [4:0]  sh_lch  = '0;
    logic        sh_len  = 1'b0;
    logic [31:0] sh_map  = '0;

    // Vector: {idle code, loopback channel, loopback enable, select map}
    localparam logic [55:0] VEC [NVEC] = '{
        {8'hA5, 8'd0,  8'd0, 32'h0000_0000},
        {8'h3C, 8'd0,  8'd1, 32'h0000_0000},
        {8'hC3, 8'd31, 8'd1, 32'h0000_0000},
        {8'hFF, 8'd7,  8'd0, 32'h8000_0001},
        {8'h5A, 8'd9,  8'd1, 32'h00F0_0F00},
        {8'h00, 8'd16, 8'd1, 32'hFFFF_FFFF},
        {8'h81, 8'd3,  8'd0, 32'h0000_0008}
    };

    e1_idle_inserter uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_start(frame_start),
        .payload_in(payload_in), .cur_slot(cur_slot), .ser_out(ser_out),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pay(input int s, input int seed);
        return 8'(s * 37 + seed);
    endfunction

    task automatic shadow(input logic [2:0] a, input logic [7:0] d);
        case (a)
            3'd0: sh_idle = d;
            3'd1: sh_lch  = d[4:0];
            3'd2: sh_len  = d[0];
            3'd4: sh_map[7:0]   = d;
            3'd5: sh_map[15:8]  = d;
            3'd6: sh_map[23:16] = d;
            3'd7: sh_map[31:24] = d;
            default: ;
        endcase
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        shadow(a, d);
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    // One frame of bit cycles; checks every timeslot byte against the model.
    task automatic run_frame(input int seed, input bit fs, input bit gaps,
                             input int mw_cycle, input logic [2:0] mw_a, input logic [7:0] mw_d);
        logic [7:0] exp_b;
        logic [7:0] got;
        string      tag;
        for (int i = 0; i < SLOTS * BITS; i++) begin
            int s = i / BITS;
            int b = BITS - 1 - (i % BITS);
            bit_en = 1'b1;
            frame_start = fs && (i == 0);
            payload_in = pay(s, seed);
            if (i == mw_cycle) begin
                wr_en = 1'b1; wr_addr = mw_a; wr_data = mw_d;
            end
            #1;
            if (b == BITS - 1) begin
                logic lp = sh_len && (5'(s) == sh_lch);
                logic mp = sh_map[s];
                check("R10 cur_slot", 32'(cur_slot), 32'(s));
                exp_b = (lp || mp) ? sh_idle : pay(s, seed);
                tag = lp ? "R3 loop slot" : (mp ? "R4 map slot" : "R5 payload slot");
            end
            if (i == mw_cycle) shadow(mw_a, mw_d);
            @(negedge clk);
            got[b] = ser_out;
            wr_en = 1'b0;
            frame_start = 1'b0;
            if (gaps) begin
                bit_en = 1'b0;
                payload_in = ~payload_in;
                repeat (2) begin
                    @(negedge clk);
                    check("R8 hold without bit_en", 32'(ser_out), 32'(got[b]));
                end
            end
            if (b == 0)
                check($sformatf("%s %0d R6", tag, s), 32'(got), 32'(exp_b));
        end
        bit_en = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 ser_out", 32'(ser_out), 0);
        check("R1 cur_slot", 32'(cur_slot), 0);
        for (int a = 0; a < 8; a++) rd_check("R1 register", 3'(a), 8'h00);

        // R2 readback and field widths
        wr(3'd0, 8'h6E);
        wr(3'd1, 8'hFF);
        wr(3'd2, 8'hFE);
        wr(3'd3, 8'hFF);
        wr(3'd6, 8'h4B);
        rd_check("R2 idle code", 3'd0, 8'h6E);
        rd_check("R2 loop channel", 3'd1, 8'h1F);
        rd_check("R2 loop enable", 3'd2, 8'h00);
        rd_check("R2 reserved", 3'd3, 8'h00);
        rd_check("R2 map byte 2", 3'd6, 8'h4B);
        rd_check("R2 map byte 0", 3'd4, 8'h00);

        // Vector table: each configuration drives one full frame.
        for (int v = 0; v < NVEC; v++) begin
            wr(3'd0, VEC[v][55:48]);
            wr(3'd1, VEC[v][47:40]);
            wr(3'd2, VEC[v][39:32]);
            for (int k = 0; k < 4; k++) wr(3'(4 + k), VEC[v][8*k +: 8]);
            rd_check("R2 idle readback", 3'd0, VEC[v][55:48]);
            run_frame(v * 11 + 3, 1'b1, 1'b0, -1, 3'd0, 8'h00);
        end

        // R8 wrap: next frame with no frame_start continues at slot 0
        run_frame(77, 1'b0, 1'b0, -1, 3'd0, 8'h00);

        // R8 stalls between bits, with payload toggling during gaps (R10)
        run_frame(5, 1'b1, 1'b1, -1, 3'd0, 8'h00);

        // R9 realign mid-frame
        bit_en = 1'b1;
        repeat (26) @(negedge clk);
        bit_en = 1'b0;
        run_frame(19, 1'b1, 1'b0, -1, 3'd0, 8'h00);

        // R7 write in mid-timeslot: slot 5 keeps payload, slot 6 idle
        wr(3'd0, 8'h99); wr(3'd2, 8'h00);
        for (int k = 0; k < 4; k++) wr(3'(4 + k), 8'h00);
        run_frame(41, 1'b1, 1'b0, 5 * BITS + 4, 3'd4, 8'h60);
        // R7 write at first bit of slot 10: slot 10 still uses old code
        wr(3'd5, 8'h04);
        run_frame(42, 1'b1, 1'b0, 10 * BITS, 3'd0, 8'h11);
        run_frame(43, 1'b1, 1'b0, -1, 3'd0, 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule